// File: doc/BRIEF.md
# Set-Bit Index Compactor

The block takes a 16-bit word and returns, two clock cycles later, the list of positions whose bit is one. Each position is a 4-bit index. The indices are packed with no gaps into the sixteen 4-bit fields of a 64-bit output. The lowest set position goes into the field at bits 3:0, the next one into bits 7:4, and so on. Fields that receive no index read zero.

Index 0 and an empty field look the same in the packed word, so the block also reports the number of set bits. That count comes out in the same cycle as the packed word. A valid flag travels through the two pipeline registers beside the data, so a consumer can tell meaningful words from idle cycles. The datapath itself runs every cycle, whatever the flag says.

Top module: `setbit_compactor`

## Requirements
- R1: The packed word, count and valid flag on the outputs reflect the input sampled two rising clock edges earlier. The input is captured on the first edge and the result on the second.
- R2: Input bits are taken in ascending position order, from bit 0 up to bit 15. The k-th set bit found, counting from k = 0, writes its 4-bit position into output bits 4k+3:4k.
- R3: Every output field at or above the field number given by the count reads zero.
- R4: The 5-bit count output holds the number of ones in the input word, from 0 to 16. It is aligned with the packed word.
- R5: valid_out equals valid_in delayed by two rising clock edges.
- R6: While rst_n is low at a rising edge, both pipeline stages are cleared: data, count and valid all go to zero. The first result after release is therefore all zero with valid_out low.
- R7: An all-ones input gives 0xFEDCBA9876543210 with count 16. An all-zero input gives zero with count 0.
- R8: Input 0x0015 gives 0x0000000000000420 with count 3.
- R9: The packed word and count are computed even when valid_in is low. valid_in affects only valid_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Marks data_in as meaningful |
| data_in | input | 16 | Word whose set-bit positions are listed |
| valid_out | output | 1 | valid_in delayed by two cycles |
| data_out | output | 64 | Packed position list, 4 bits per field, lowest field first |
| count_out | output | 5 | Number of set bits in the word behind data_out |

## Verification
Every result is due on the second rising edge after the input is presented. The bench drives inputs on falling edges and reads the outputs on the falling edge two cycles later. In the exhaustive sweep it keeps a two-deep history of what it drove and compares each output against the entry that is exactly two falling edges old. The reset scenario reads the outputs one edge into reset and one edge after release, where the cleared first stage must still show through. The full result is checked one edge after that.

// File: rtl/sbc_pkg.sv
// Package sbc_pkg
// Shared defaults for the set-bit index compactor.
// Assumes: every module derives its widths from SBC_IN_W.
package sbc_pkg;
    // Default input word width.
    localparam int SBC_IN_W = 16;

    // Bits needed to hold a position index inside a word of width n.
    function automatic int sbc_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Bits needed to hold a set-bit count from 0 to n.
    function automatic int sbc_cnt_w(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/sbc_capture.sv
// Module sbc_capture
// First pipeline stage. It registers the input word and its valid flag.
// Assumes: synchronous active-low reset. The word is captured every cycle.
module sbc_capture #(
    parameter int IN_W = sbc_pkg::SBC_IN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [IN_W-1:0] word_in,
    output logic            valid_q,
    output logic [IN_W-1:0] word_q
);
    // Capture the word and the flag, or clear both in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            word_q  <= word_in;
            valid_q <= valid_in;
        end
    end
endmodule

// File: rtl/sbc_rank.sv
// Module sbc_rank
// Combinational prefix counter. Output rank[i] is the number of set bits
// below position i, which is also the field that bit i writes when it is set.
// rank[IN_W] is the total population count.
// Assumes: the input is stable within a cycle. There is no state.
module sbc_rank #(
    parameter int IN_W  = sbc_pkg::SBC_IN_W,
    localparam int CNT_W = sbc_pkg::sbc_cnt_w(IN_W)
) (
    input  logic [IN_W-1:0]  word,
    output logic [CNT_W-1:0] rank [IN_W+1],
    output logic [CNT_W-1:0] total
);
    // Ripple the prefix sum from bit 0 upward.
    always_comb begin
        rank[0] = '0;
        for (int i = 0; i < IN_W; i++) begin
            rank[i+1] = rank[i] + CNT_W'(word[i]);
        end
    end

    // The full sum is the number of set bits.
    assign total = rank[IN_W];
endmodule

// File: rtl/sbc_pack.sv
// Module sbc_pack
// Combinational packer. Field s receives index i when bit i is set and its
// rank equals s. At most one bit matches a field, so the matches are ORed.
// Fields with no match stay zero.
// Assumes: the rank vector comes from sbc_rank on the same word.
module sbc_pack #(
    parameter int IN_W   = sbc_pkg::SBC_IN_W,
    localparam int IDX_W = sbc_pkg::sbc_idx_w(IN_W),
    localparam int CNT_W = sbc_pkg::sbc_cnt_w(IN_W),
    localparam int OUT_W = IN_W * IDX_W
) (
    input  logic [IN_W-1:0]  word,
    input  logic [CNT_W-1:0] rank [IN_W+1],
    output logic [OUT_W-1:0] packed_word
);
    genvar s;
    generate
        for (s = 0; s < IN_W; s++) begin : g_field
            logic [IDX_W-1:0] field;
            // OR together the index of every bit that targets field s.
            always_comb begin
                field = '0;
                for (int i = 0; i < IN_W; i++) begin
                    if (word[i] && (rank[i] == CNT_W'(s))) begin
                        field = field | IDX_W'(i);
                    end
                end
            end
            assign packed_word[s*IDX_W +: IDX_W] = field;
        end
    endgenerate
endmodule

// File: rtl/sbc_result.sv
// Module sbc_result
// Second pipeline stage. It registers the packed list, the count and the
// valid flag together so that all three leave the block aligned.
// Assumes: synchronous active-low reset.
module sbc_result #(
    parameter int IN_W   = sbc_pkg::SBC_IN_W,
    localparam int IDX_W = sbc_pkg::sbc_idx_w(IN_W),
    localparam int CNT_W = sbc_pkg::sbc_cnt_w(IN_W),
    localparam int OUT_W = IN_W * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_d,
    input  logic [OUT_W-1:0] packed_d,
    input  logic [CNT_W-1:0] count_d,
    output logic             valid_q,
    output logic [OUT_W-1:0] packed_q,
    output logic [CNT_W-1:0] count_q
);
    // Load the result set, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            packed_q <= '0;
            count_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            packed_q <= packed_d;
            count_q  <= count_d;
            valid_q  <= valid_d;
        end
    end

    // R6: a reset edge leaves the result stage empty.
    assert_reset_clears_R6: assert property (@(posedge clk)
        !rst_n |=> (packed_q == '0) && (count_q == '0) && !valid_q);

    // R4: the count never goes above the word width.
    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(IN_W));
endmodule

// File: rtl/setbit_compactor.sv
// Module setbit_compactor
// Top level. Stage 1 captures the word, the rank and pack logic compacts
// the set-bit positions, and stage 2 registers the list, the count and the
// valid flag. Latency is two rising edges.
// Assumes: synchronous active-low reset. The datapath runs whatever valid_in is.
module setbit_compactor #(
    parameter int IN_W   = sbc_pkg::SBC_IN_W,
    localparam int IDX_W = sbc_pkg::sbc_idx_w(IN_W),
    localparam int CNT_W = sbc_pkg::sbc_cnt_w(IN_W),
    localparam int OUT_W = IN_W * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [IN_W-1:0]  data_in,
    output logic             valid_out,
    output logic [OUT_W-1:0] data_out,
    output logic [CNT_W-1:0] count_out
);
    logic             s1_valid;
    logic [IN_W-1:0]  s1_word;
    logic [CNT_W-1:0] s1_rank [IN_W+1];
    logic [CNT_W-1:0] s1_total;
    logic [OUT_W-1:0] s1_packed;

    sbc_capture #(.IN_W(IN_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_in (valid_in),
        .word_in  (data_in),
        .valid_q  (s1_valid),
        .word_q   (s1_word)
    );

    sbc_rank #(.IN_W(IN_W)) u_rank (
        .word  (s1_word),
        .rank  (s1_rank),
        .total (s1_total)
    );

    sbc_pack #(.IN_W(IN_W)) u_pack (
        .word        (s1_word),
        .rank        (s1_rank),
        .packed_word (s1_packed)
    );

    sbc_result #(.IN_W(IN_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_d  (s1_valid),
        .packed_d (s1_packed),
        .count_d  (s1_total),
        .valid_q  (valid_out),
        .packed_q (data_out),
        .count_q  (count_out)
    );

    // Edges since reset release, saturating at 2. Used only by the checks below.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)           warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R5: the flag comes out two edges after it went in.
    assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (valid_out == $past(valid_in, 2)));

    // R1 and R4: the count matches the population of the word taken two edges earlier.
    assert_count_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (count_out == CNT_W'($countones($past(data_in, 2)))));

    genvar f;
    generate
        for (f = 0; f < IN_W; f++) begin : g_chk
            // R3: fields at or past the count read zero.
            assert_empty_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (CNT_W'(f) >= count_out) |-> (data_out[f*IDX_W +: IDX_W] == '0));
            if (f < IN_W - 1) begin : g_order
                // R2: filled fields hold strictly ascending positions.
                assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    (CNT_W'(f + 1) < count_out) |->
                    (data_out[(f+1)*IDX_W +: IDX_W] > data_out[f*IDX_W +: IDX_W]));
            end
        end
    endgenerate
endmodule

// File: tb/setbit_compactor_test.sv
// Directed bench for setbit_compactor. Each scenario is a task that checks
// its own results. Inputs change on falling edges, and outputs are read on
// falling edges.
module setbit_compactor_test;
    localparam int IN_W  = 16;
    localparam int OUT_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid_in = 1'b0;
    logic [IN_W-1:0]  data_in = '0;
    logic             valid_out;
    logic [OUT_W-1:0] data_out;
    logic [4:0]       count_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    setbit_compactor uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .data_in   (data_in),
        .valid_out (valid_out),
        .data_out  (data_out),
        .count_out (count_out)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Reference model: scan upward and place each set position in the next free field.
    function automatic logic [OUT_W-1:0] ref_pack(input logic [IN_W-1:0] w);
        logic [OUT_W-1:0] r = '0;
        int j = 0;
        for (int i = 0; i < IN_W; i++) begin
            if (w[i]) begin
                r[j*4 +: 4] = 4'(i);
                j++;
            end
        end
        return r;
    endfunction

    function automatic logic [4:0] ref_count(input logic [IN_W-1:0] w);
        return 5'($countones(w));
    endfunction

    task automatic check(input string req, input logic [OUT_W-1:0] got,
                         input logic [OUT_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one word at a falling edge, then read the result two edges later.
    task automatic apply(input logic [IN_W-1:0] w, input logic v);
        @(negedge clk);
        data_in  = w;
        valid_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 data", data_out, '0);
        check("R6 count", 64'(count_out), 64'd0);
        check("R6 valid", 64'(valid_out), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_example;
        apply(16'h0015, 1'b1);
        check("R8 data", data_out, 64'h0000_0000_0000_0420);
        check("R8 count", 64'(count_out), 64'd3);
        check("R1 valid", 64'(valid_out), 64'd1);
    endtask

    task automatic t_extremes;
        apply(16'hFFFF, 1'b1);
        check("R7 ones data", data_out, 64'hFEDC_BA98_7654_3210);
        check("R7 ones count", 64'(count_out), 64'd16);
        apply(16'h0000, 1'b1);
        check("R7 zero data", data_out, '0);
        check("R7 zero count", 64'(count_out), 64'd0);
        apply(16'h8000, 1'b1);
        check("R2 top bit", data_out, 64'h0000_0000_0000_000F);
        check("R3 single count", 64'(count_out), 64'd1);
    endtask

    task automatic t_valid_low;
        apply(16'h8001, 1'b0);
        check("R9 data", data_out, 64'h0000_0000_0000_00F0);
        check("R9 count", 64'(count_out), 64'd2);
        check("R5 valid low", 64'(valid_out), 64'd0);
    endtask

    task automatic t_reset_midstream;
        @(negedge clk);
        data_in = 16'hFFFF;
        valid_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 mid data", data_out, '0);
        check("R6 mid valid", 64'(valid_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 first after release", data_out, '0);
        check("R6 first valid", 64'(valid_out), 64'd0);
        @(negedge clk);
        check("R1 refill data", data_out, 64'hFEDC_BA98_7654_3210);
        check("R1 refill valid", 64'(valid_out), 64'd1);
    endtask

    // Stream every input value back to back and compare with a two-deep history.
    task automatic t_exhaustive;
        logic [IN_W-1:0] h1 = '0, h2 = '0;
        logic v1 = 1'b0, v2 = 1'b0;
        for (int n = 0; n < (1 << IN_W) + 2; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                check("R2 sweep data", data_out, ref_pack(h2));
                check("R4 sweep count", 64'(count_out), 64'(ref_count(h2)));
                check("R5 sweep valid", 64'(valid_out), 64'(v2));
            end
            h2 = h1;
            v2 = v1;
            h1 = 16'(n);
            v1 = n[0] ^ n[5];
            data_in  = h1;
            valid_in = v1;
        end
    endtask

    initial begin
        t_reset_state();
        t_example();
        t_extremes();
        t_valid_low();
        t_reset_midstream();
        t_exhaustive();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule